// File: doc/BRIEF.md
# Voltage-Frequency Transition Sequencer

This block moves a clock domain from one operating point to another. An operating point pairs a PLL frequency ratio with a regulator voltage code. Software writes a target point. The sequencer compares it with the point now in force and chooses the order of the steps from that comparison. When the frequency goes up, the voltage code is walked to its target first and the PLL is retuned after it. When the frequency goes down, the PLL is retuned first and the voltage follows. The voltage code moves by one code per step. A dwell timer paces the steps. The cores are stalled only while the PLL reacquires lock.

A write that lands while a transition is running is parked in a single slot and started once the running transition is over. A later write replaces whatever is parked. A lock watchdog limits the length of the stall. If lock is not reported within the programmed cycle budget, the stall is released, a sticky error flag is raised, and the sequence carries on.

Top module: `vf_seq`

## Requirements
- R1: While reset is low, and after it is released, `vid_o` holds the reset voltage code (default 20) and `ratio_o` holds the reset ratio (default 10). `stall_o`, `busy_o` and `timeout_o` are all 0.
- R2: When the target ratio is above the current ratio, `vid_o` reaches the target code before `ratio_o` changes. `ratio_o` changes on the same edge on which `stall_o` rises.
- R3: When the target ratio is below the current ratio, `ratio_o` changes and `stall_o` rises on the edge after the request is taken. `vid_o` keeps its old value until the stall has ended, and only then walks to the target.
- R4: `vid_o` changes by exactly one code per step. After each step the sequencer waits `dwell_cycles` cycles, so two consecutive steps are `dwell_cycles`+1 cycles apart.
- R5: `stall_o` is high only while the PLL is relocking. It falls on the first edge at which `pll_lock` is sampled high, so the stall lasts as many cycles as the PLL takes to lock.
- R6: A write (`req_valid` high for one cycle) made while a transition is in progress is held and started after that transition ends. Only the most recent such write is kept.
- R7: If `pll_lock` is not seen within `lock_budget` stall cycles, `stall_o` falls after exactly `lock_budget` cycles and `timeout_o` goes to 1. `timeout_o` stays at 1 until reset. The rest of the sequence still runs to the target.
- R8: A target equal to the current point causes no stall and no change of `vid_o`. `busy_o` is high for exactly one cycle.
- R9: `busy_o` is high from the cycle after a write is accepted until the last step of the transition has completed.
- R10: A target with an equal ratio but a different voltage code walks `vid_o` to the new code without asserting `stall_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | One-cycle strobe of a software target write |
| req_ratio | input | RATIO_W | Target PLL ratio |
| req_vid | input | VID_W | Target voltage code |
| dwell_cycles | input | DWELL_W | Wait after each voltage step |
| lock_budget | input | LOCK_W | Maximum number of stall cycles before timeout |
| pll_lock | input | 1 | PLL lock indication |
| vid_o | output | VID_W | Voltage code sent to the regulator |
| ratio_o | output | RATIO_W | Ratio command sent to the PLL |
| stall_o | output | 1 | Cores unavailable (PLL relocking) |
| busy_o | output | 1 | A transition is accepted or in progress |
| timeout_o | output | 1 | Sticky lock-timeout error |

## Verification
Two events can fall on the same clock edge. In the first, a new write lands on the edge where the parked request is taken into execution. The bench provokes this with two writes on consecutive cycles from idle. The first write must run to completion, the second must wait in the slot and then run, and busy must not drop in between. In the second, the lock watchdog expires on the edge where lock would have been checked. The bench provokes this by holding the lock low for longer than the budget. Here the stall must end after exactly the budget, and the voltage walk that follows must still reach its target. A behavioural model in the bench judges both cases cycle by cycle.

// File: rtl/vf_pkg.sv
package vf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_RAMP_PRE  = 2'd1,
        ST_RELOCK    = 2'd2,
        ST_RAMP_POST = 2'd3
    } vf_state_e;
endpackage

// File: rtl/vf_pending.sv
module vf_pending #(
    parameter int RATIO_W = 8,
    parameter int VID_W   = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [RATIO_W-1:0] wr_ratio,
    input  logic [VID_W-1:0]   wr_vid,
    input  logic               take,
    output logic               valid,
    output logic [RATIO_W-1:0] ratio,
    output logic [VID_W-1:0]   vid
);
    typedef struct packed {
        logic               v;
        logic [RATIO_W-1:0] r;
        logic [VID_W-1:0]   c;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (take) slot_d.v = 1'b0;
        if (wr_en) begin
            slot_d.v = 1'b1;
            slot_d.r = wr_ratio;
            slot_d.c = wr_vid;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign valid = slot_q.v;
    assign ratio = slot_q.r;
    assign vid   = slot_q.c;

    // R6: a newer write always replaces the parked request
    a_r6_last_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (valid && ratio == $past(wr_ratio) && vid == $past(wr_vid)));
endmodule

// File: rtl/vf_dwell_timer.sv
module vf_dwell_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] val,
    input  logic         dec,
    output logic         zero
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)       cnt_d = '0;
        else if (load) cnt_d = val;
        else if (dec)  cnt_d = cnt_q - W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);

    // R4: the dwell count never wraps below zero
    a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !clr && !load) |-> !zero);
endmodule

// File: rtl/vf_lock_timer.sv
module vf_lock_timer #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    input  logic [W-1:0] budget,
    output logic         expired
);
    logic [W-1:0] cnt_d, cnt_q;
    logic [W:0]   used;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)      cnt_d = '0;
        else if (inc) cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign used    = {1'b0, cnt_q} + (W+1)'(1);
    assign expired = (used >= {1'b0, budget});

    // R7: the counter only advances while the budget is not used up
    a_r7_inc_below_budget: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr) |=> (cnt_q != '0));
endmodule

// File: rtl/vf_seq.sv
module vf_seq
    import vf_pkg::*;
#(
    parameter int RATIO_W   = 8,
    parameter int VID_W     = 6,
    parameter int DWELL_W   = 8,
    parameter int LOCK_W    = 10,
    parameter int RST_RATIO = 10,
    parameter int RST_VID   = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [RATIO_W-1:0] req_ratio,
    input  logic [VID_W-1:0]   req_vid,
    input  logic [DWELL_W-1:0] dwell_cycles,
    input  logic [LOCK_W-1:0]  lock_budget,
    input  logic               pll_lock,
    output logic [VID_W-1:0]   vid_o,
    output logic [RATIO_W-1:0] ratio_o,
    output logic               stall_o,
    output logic               busy_o,
    output logic               timeout_o
);
    localparam logic [RATIO_W-1:0] RATIO_INIT = RATIO_W'(RST_RATIO);
    localparam logic [VID_W-1:0]   VID_INIT   = VID_W'(RST_VID);

    typedef struct packed {
        vf_state_e          st;
        logic [RATIO_W-1:0] ratio;
        logic [VID_W-1:0]   vid;
        logic [RATIO_W-1:0] tgt_ratio;
        logic [VID_W-1:0]   tgt_vid;
        logic               down;
        logic               timeout;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic               pend_v;
    logic [RATIO_W-1:0] pend_r;
    logic [VID_W-1:0]   pend_c;
    logic               take;
    logic               dw_clr, dw_load, dw_dec, dw_zero;
    logic               lk_clr, lk_inc, lk_expired;

    assign take = (ctl_q.st == ST_IDLE) && pend_v;

    vf_pending #(.RATIO_W(RATIO_W), .VID_W(VID_W)) u_pend (
        .clk(clk), .rst_n(rst_n),
        .wr_en(req_valid), .wr_ratio(req_ratio), .wr_vid(req_vid),
        .take(take),
        .valid(pend_v), .ratio(pend_r), .vid(pend_c)
    );

    vf_dwell_timer #(.W(DWELL_W)) u_dwell (
        .clk(clk), .rst_n(rst_n),
        .clr(dw_clr), .load(dw_load), .val(dwell_cycles), .dec(dw_dec),
        .zero(dw_zero)
    );

    vf_lock_timer #(.W(LOCK_W)) u_lock (
        .clk(clk), .rst_n(rst_n),
        .clr(lk_clr), .inc(lk_inc), .budget(lock_budget),
        .expired(lk_expired)
    );

    always_comb begin
        ctl_d   = ctl_q;
        dw_clr  = 1'b0;
        dw_load = 1'b0;
        dw_dec  = 1'b0;
        lk_clr  = 1'b0;
        lk_inc  = 1'b0;
        case (ctl_q.st)
            ST_IDLE: begin
                if (pend_v) begin
                    ctl_d.tgt_ratio = pend_r;
                    ctl_d.tgt_vid   = pend_c;
                    ctl_d.down      = 1'b0;
                    if (pend_r > ctl_q.ratio) begin
                        ctl_d.st = ST_RAMP_PRE;
                        dw_clr   = 1'b1;
                    end else if (pend_r < ctl_q.ratio) begin
                        ctl_d.st    = ST_RELOCK;
                        ctl_d.ratio = pend_r;
                        ctl_d.down  = 1'b1;
                        lk_clr      = 1'b1;
                    end else if (pend_c != ctl_q.vid) begin
                        ctl_d.st = ST_RAMP_POST;
                        dw_clr   = 1'b1;
                    end
                end
            end
            ST_RAMP_PRE, ST_RAMP_POST: begin
                if (ctl_q.vid == ctl_q.tgt_vid) begin
                    if (ctl_q.st == ST_RAMP_PRE) begin
                        ctl_d.st    = ST_RELOCK;
                        ctl_d.ratio = ctl_q.tgt_ratio;
                        lk_clr      = 1'b1;
                    end else begin
                        ctl_d.st = ST_IDLE;
                    end
                end else if (dw_zero) begin
                    ctl_d.vid = (ctl_q.tgt_vid > ctl_q.vid) ? ctl_q.vid + VID_W'(1)
                                                            : ctl_q.vid - VID_W'(1);
                    dw_load   = 1'b1;
                end else begin
                    dw_dec = 1'b1;
                end
            end
            ST_RELOCK: begin
                if (pll_lock || lk_expired) begin
                    if (!pll_lock) ctl_d.timeout = 1'b1;
                    if (ctl_q.down) begin
                        ctl_d.st = ST_RAMP_POST;
                        dw_clr   = 1'b1;
                    end else begin
                        ctl_d.st = ST_IDLE;
                    end
                end else begin
                    lk_inc = 1'b1;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.st        <= ST_IDLE;
            ctl_q.ratio     <= RATIO_INIT;
            ctl_q.vid       <= VID_INIT;
            ctl_q.tgt_ratio <= RATIO_INIT;
            ctl_q.tgt_vid   <= VID_INIT;
            ctl_q.down      <= 1'b0;
            ctl_q.timeout   <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign vid_o     = ctl_q.vid;
    assign ratio_o   = ctl_q.ratio;
    assign stall_o   = (ctl_q.st == ST_RELOCK);
    assign busy_o    = (ctl_q.st != ST_IDLE) || pend_v;
    assign timeout_o = ctl_q.timeout;

    // R4: voltage code moves by exactly one per change
    a_r4_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
        (vid_o != $past(vid_o)) |->
        (vid_o == $past(vid_o) + VID_W'(1) || vid_o == $past(vid_o) - VID_W'(1)));
    // R5: the PLL ratio only moves as a stall begins
    a_r5_ratio_with_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio_o != $past(ratio_o)) |-> $rose(stall_o));
    // R3: voltage is frozen while the PLL relocks
    a_r3_vid_frozen_in_stall: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |-> $stable(vid_o));
    // R2: an upward move reaches the voltage target before relock
    a_r2_vid_before_relock: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(stall_o) && !ctl_q.down) |-> (vid_o == ctl_q.tgt_vid));
    // R7: the timeout flag is sticky
    a_r7_timeout_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |=> timeout_o);
    // R9: a stall never occurs outside a busy period
    a_r9_stall_implies_busy: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |-> busy_o);
    // R6: a parked request survives a running transition
    a_r6_pending_held: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_v && ctl_q.st != ST_IDLE) |=> pend_v);
endmodule

// File: tb/vf_seq_test.sv
`timescale 1ns/1ps
module vf_seq_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [7:0] req_ratio = '0;
    logic [5:0] req_vid = '0;
    logic [7:0] dwell_cycles = '0;
    logic [9:0] lock_budget = 10'd50;
    logic       pll_lock = 1'b0;
    logic [5:0] vid_o;
    logic [7:0] ratio_o;
    logic       stall_o, busy_o, timeout_o;

    always #2 clk = ~clk;

    vf_seq uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ratio(req_ratio),
        .req_vid(req_vid), .dwell_cycles(dwell_cycles), .lock_budget(lock_budget),
        .pll_lock(pll_lock), .vid_o(vid_o), .ratio_o(ratio_o), .stall_o(stall_o),
        .busy_o(busy_o), .timeout_o(timeout_o)
    );

    int tests = 0;
    int fails = 0;
    string scen = "R1";

    task automatic chk(string tag, string what, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s (%s) %s: actual %0d expected %0d", tag, scen, what, act, exp);
        end
    endtask

    // PLL stand-in: lock after lock_delay cycles of stall
    int lock_delay = 3;
    int pll_cnt = 0;
    always @(negedge clk) begin
        if (stall_o) begin
            pll_cnt++;
            pll_lock = (pll_cnt >= lock_delay);
        end else begin
            pll_cnt = 0;
            pll_lock = 1'b0;
        end
    end

    // behavioural reference: phase list 1 = voltage walk, 2 = relock
    int m_vid, m_ratio, m_to, m_cnt, m_lk, t_ratio, t_vid;
    int ph[$];
    int qr[$];
    int qv[$];
    bit had;
    int pr, pv;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_vid = 20; m_ratio = 10; m_to = 0; m_cnt = 0; m_lk = 0;
            ph.delete(); qr.delete(); qv.delete();
        end else begin
            had = (qr.size() > 0) && (ph.size() == 0);
            if (had) begin pr = qr[0]; pv = qv[0]; end
            if (req_valid) begin
                qr = {int'(req_ratio)};
                qv = {int'(req_vid)};
            end else if (had) begin
                qr.delete(); qv.delete();
            end
            if (had) begin
                t_ratio = pr; t_vid = pv;
                if (pr > m_ratio) begin ph = {1, 2}; m_cnt = 0; end
                else if (pr < m_ratio) begin ph = {2, 1}; m_ratio = pr; m_lk = 0; end
                else if (pv != m_vid) begin ph = {1}; m_cnt = 0; end
            end else if (ph.size() > 0) begin
                if (ph[0] == 1) begin
                    if (m_vid == t_vid) begin
                        void'(ph.pop_front());
                        if (ph.size() > 0) begin m_ratio = t_ratio; m_lk = 0; end
                    end else if (m_cnt == 0) begin
                        m_vid = (t_vid > m_vid) ? m_vid + 1 : m_vid - 1;
                        m_cnt = int'(dwell_cycles);
                    end else begin
                        m_cnt--;
                    end
                end else begin
                    if (pll_lock || (m_lk + 1 >= int'(lock_budget))) begin
                        if (!pll_lock) m_to = 1;
                        void'(ph.pop_front());
                        if (ph.size() > 0) m_cnt = 0;
                    end else begin
                        m_lk++;
                    end
                end
            end
        end
    end

    // per-cycle comparison and observation
    int cyc = 0, last_vid_cyc = 0, last_gap = 0, stall_cycles = 0, busy_cycles = 0;
    int prev_vid = 20, prev_ratio = 10, vid_at_rchg = -1;
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R4", "vid_o", int'(vid_o), m_vid);
            chk("R2", "ratio_o", int'(ratio_o), m_ratio);
            chk("R5", "stall_o", int'(stall_o), (ph.size() > 0 && ph[0] == 2) ? 1 : 0);
            chk("R9", "busy_o", int'(busy_o), (ph.size() > 0 || qr.size() > 0) ? 1 : 0);
            chk("R7", "timeout_o", int'(timeout_o), m_to);
            cyc++;
            if (stall_o) stall_cycles++;
            if (busy_o) busy_cycles++;
            if (int'(vid_o) != prev_vid) begin
                last_gap = cyc - last_vid_cyc;
                last_vid_cyc = cyc;
            end
            if (int'(ratio_o) != prev_ratio) vid_at_rchg = int'(vid_o);
            prev_vid = int'(vid_o);
            prev_ratio = int'(ratio_o);
        end
    end

    task automatic write_pt(int r, int v);
        @(negedge clk);
        req_valid = 1'b1; req_ratio = 8'(r); req_vid = 6'(v);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        for (int n = 0; n < 5000 && busy_o; n++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic clear_obs();
        stall_cycles = 0; busy_cycles = 0; vid_at_rchg = -1;
    endtask

    task automatic run_all();
        repeat (3) @(negedge clk);
        chk("R1", "vid in reset", int'(vid_o), 20);
        chk("R1", "ratio in reset", int'(ratio_o), 10);
        chk("R1", "busy in reset", int'(busy_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "stall after reset", int'(stall_o), 0);
        chk("R1", "timeout after reset", int'(timeout_o), 0);

        // upward move: voltage first, then relock
        scen = "R2"; dwell_cycles = 8'd2; clear_obs();
        write_pt(14, 24); wait_idle();
        chk("R2", "vid when ratio moved", vid_at_rchg, 24);
        chk("R5", "stall length", stall_cycles, 3);
        chk("R2", "final ratio", int'(ratio_o), 14);

        // downward move: relock first, then voltage
        scen = "R3"; dwell_cycles = 8'd0; clear_obs();
        write_pt(8, 18); wait_idle();
        chk("R3", "vid when ratio moved", vid_at_rchg, 24);
        chk("R3", "final vid", int'(vid_o), 18);

        // same point: no stall, one busy cycle
        scen = "R8"; clear_obs();
        write_pt(8, 18); wait_idle();
        chk("R8", "busy cycles", busy_cycles, 1);
        chk("R8", "stall cycles", stall_cycles, 0);
        chk("R8", "vid", int'(vid_o), 18);

        // same ratio, new voltage: walk only
        scen = "R10"; dwell_cycles = 8'd1; clear_obs();
        write_pt(8, 21); wait_idle();
        chk("R10", "stall cycles", stall_cycles, 0);
        chk("R10", "final vid", int'(vid_o), 21);
        chk("R4", "step spacing", last_gap, 2);

        // writes during a transition: last one wins
        scen = "R6"; dwell_cycles = 8'd3; clear_obs();
        write_pt(16, 26);
        repeat (3) @(negedge clk);
        write_pt(12, 22);
        write_pt(9, 19);
        wait_idle();
        chk("R6", "final ratio", int'(ratio_o), 9);
        chk("R6", "final vid", int'(vid_o), 19);

        // back-to-back writes from idle: take and park on the same edge
        scen = "R9"; dwell_cycles = 8'd0;
        @(negedge clk);
        req_valid = 1'b1; req_ratio = 8'd11; req_vid = 6'd21;
        @(negedge clk);
        req_ratio = 8'd13; req_vid = 6'd25;
        @(negedge clk);
        req_valid = 1'b0;
        wait_idle();
        chk("R9", "final ratio", int'(ratio_o), 13);
        chk("R9", "final vid", int'(vid_o), 25);

        // lock never arrives: watchdog ends the stall
        scen = "R7"; lock_delay = 1000; lock_budget = 10'd6; clear_obs();
        write_pt(15, 27); wait_idle();
        chk("R7", "stall length", stall_cycles, 6);
        chk("R7", "timeout flag", int'(timeout_o), 1);
        chk("R7", "ratio after timeout", int'(ratio_o), 15);

        // later downward move still completes, flag stays set
        scen = "R3"; lock_delay = 2; lock_budget = 10'd50; dwell_cycles = 8'd1; clear_obs();
        write_pt(11, 22); wait_idle();
        chk("R3", "final vid", int'(vid_o), 22);
        chk("R5", "stall length", stall_cycles, 2);
        chk("R7", "timeout still set", int'(timeout_o), 1);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                tests++;
                fails++;
                $display("FAIL watchdog: actual hung expected done");
            end
        join_any
        disable fork;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule